// File: doc/BRIEF.md
# Core Reset and Halt Sequencer

This block decides when a small microcontroller core is running, frozen or being initialized. It watches an active-low external reset line and takes it as a real reset only once the line has stayed low across three instruction cycles. Shorter dips are treated as noise. An accepted reset gives the core a synchronous reset level for the whole time the line stays low. The same level is also the value loaded into the serial-clock output latch, so that the serial clock line comes out of reset acting as a clock output. The block has no output that clears data memory.

The block can freeze the core in two ways: a halt instruction seen by the decoder, or an external halt pin driven high when the pin option is built in. While frozen, the core clock enable stays low, so no core register changes. A falling level on the halt pin resumes execution exactly where it stopped. A qualified reset also leaves the halted state, but it initializes the core instead of resuming it.

Both asynchronous pins pass through a synchronizer chain before they are used. An asynchronous power-on input sets the block to a known state and produces one cycle of core reset after it is released.

Top module: `core_run_ctrl`

## Requirements
- R1: After the synchronizer delay (2 clocks), once the reset pin has been seen low at three rising clock edges where `cyc_en_i` is high, `core_rst_o` goes high. It stays high until the synchronized pin reads high, and it drops at the clock edge that follows.
- R2: A low on the reset pin that spans fewer than three instruction-cycle ticks never raises `core_rst_o`. Any synchronized high clears the count of low ticks back to zero.
- R3: `sk_latch_set_o` is high in exactly the cycles where `core_rst_o` is high.
- R4: While `arst_n` is low, `core_rst_o` is 1 and `halted_o` is 0. After release, `core_rst_o` stays 1 up to the first rising clock edge and is 0 after it.
- R5: When `halt_req_i` and `cyc_en_i` are both high at a clock edge while running and not in reset, `halted_o` is 1 from that edge on. `core_clk_en_o` is still high in that last cycle, so the instruction completes.
- R6: While `halted_o` is 1, `core_clk_en_o` is 0 whatever `cyc_en_i` does. Outside halt, `core_clk_en_o` follows `cyc_en_i`.
- R7: With the pin option enabled (the default), a synchronized high on `halt_pin_i` halts the core at the next clock edge. `halt_req_i` has no effect while halted.
- R8: While halted, a synchronized high-to-low change of `halt_pin_i` clears `halted_o` at the next clock edge. A pin that simply stays low does not resume the core.
- R9: A qualified reset while halted clears `halted_o` and raises `core_rst_o`.
- R10: While `core_rst_o` is high, neither `halt_req_i` nor `halt_pin_i` can set `halted_o`. A resume edge that arrives during reset leaves `core_rst_o` asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| cyc_en_i | input | 1 | One-clock tick marking the end of each instruction cycle |
| rst_pin_n_i | input | 1 | External reset line, active low, asynchronous |
| halt_req_i | input | 1 | Halt instruction executing in the current instruction cycle |
| halt_pin_i | input | 1 | Received level of the halt I/O pin, asynchronous |
| core_rst_o | output | 1 | Synchronous reset level to the core registers |
| core_clk_en_o | output | 1 | Core clock enable; low while halted |
| sk_latch_set_o | output | 1 | Loads the set value into the serial-clock output latch |
| halted_o | output | 1 | Core is frozen |

## Verification
The assertions assume that `cyc_en_i` is a single-clock tick, that `halt_req_i` is only meaningful at a tick, and that the pins may change at any time because the synchronizers absorb their timing. The stimulus generates ticks on a fixed divide-by-four pattern. It changes the pins only away from the active edge, and it holds the halt request for a whole instruction cycle or longer. A behavioural model that is stepped on every clock compares each output on every cycle. This includes the cycles where a resume edge and a reset overlap.

// File: rtl/runctl_pkg.sv
package runctl_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } run_state_e;

  // Count of qualifying low ticks on the reset line; saturates at limit.
  function automatic int unsigned low_count_next(int unsigned cur, logic pin_low,
                                                 logic tick, int unsigned limit);
    if (!pin_low) return 0;
    if (tick && cur < limit) return cur + 1;
    return cur;
  endfunction

  // Run/halt decision; reset dominates everything, then entry or resume.
  function automatic run_state_e run_next(run_state_e cur, logic rst_take,
                                          logic instr_halt, logic pin_halt,
                                          logic pin_resume);
    if (rst_take) return ST_RUN;
    if (cur == ST_RUN) return (instr_halt || pin_halt) ? ST_HALT : ST_RUN;
    return pin_resume ? ST_RUN : ST_HALT;
  endfunction

endpackage

// File: rtl/runctl_sync.sv
module runctl_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("runctl_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= {STAGES{INIT}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/runctl_rst_qual.sv
module runctl_rst_qual
  import runctl_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 3
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cyc_en_i,
  input  logic rst_sync_n_i,
  output logic rst_take_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) low_cnt_q <= '0;
    else low_cnt_q <= CNT_W'(low_count_next(int'(low_cnt_q), ~rst_sync_n_i,
                                            cyc_en_i, RST_CYCLES));
  end

  assign rst_take_o = (low_cnt_q == CNT_W'(RST_CYCLES));

  // R1: acceptance only ever begins on a tick with the line low
  a_r1_take_on_low_tick: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_take_o) |-> ($past(cyc_en_i) && !$past(rst_sync_n_i)));

  // R2: a high line cancels any acceptance at the next edge
  a_r2_high_clears: assert property (@(posedge clk) disable iff (!arst_n)
    rst_sync_n_i |=> !rst_take_o);
endmodule

// File: rtl/runctl_halt.sv
module runctl_halt
  import runctl_pkg::*;
#(
  parameter bit PIN_HALT_EN = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cyc_en_i,
  input  logic halt_req_i,
  input  logic halt_pin_s_i,
  input  logic rst_i,
  output logic halted_o
);
  run_state_e state_q;
  logic       pin_prev_q;
  logic       instr_halt, pin_halt, pin_resume;

  assign instr_halt = halt_req_i & cyc_en_i;
  assign pin_halt   = PIN_HALT_EN & halt_pin_s_i;
  assign pin_resume = PIN_HALT_EN & pin_prev_q & ~halt_pin_s_i;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q    <= ST_RUN;
      pin_prev_q <= 1'b0;
    end else begin
      state_q    <= run_next(state_q, rst_i, instr_halt, pin_halt, pin_resume);
      pin_prev_q <= halt_pin_s_i;
    end
  end

  assign halted_o = (state_q == ST_HALT);

  // R5: a halt instruction at the cycle end freezes the core
  a_r5_instr_enters: assert property (@(posedge clk) disable iff (!arst_n)
    (!halted_o && instr_halt && !rst_i) |=> halted_o);

  // R6: without a resume or reset, halt persists
  a_r6_halt_holds: assert property (@(posedge clk) disable iff (!arst_n)
    (halted_o && !pin_resume && !rst_i) |=> halted_o);

  // R8: a falling halt pin resumes execution
  a_r8_resume: assert property (@(posedge clk) disable iff (!arst_n)
    (halted_o && pin_resume) |=> !halted_o);

  // R9: reset always leaves halt
  a_r9_reset_exits: assert property (@(posedge clk) disable iff (!arst_n)
    rst_i |=> !halted_o);
endmodule

// File: rtl/core_run_ctrl.sv
module core_run_ctrl #(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned RST_CYCLES  = 3,
  parameter bit          PIN_HALT_EN = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cyc_en_i,
  input  logic rst_pin_n_i,
  input  logic halt_req_i,
  input  logic halt_pin_i,
  output logic core_rst_o,
  output logic core_clk_en_o,
  output logic sk_latch_set_o,
  output logic halted_o
);
  logic rst_sync_n, halt_pin_s, rst_take, por_q;

  runctl_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_rst_sync (
    .clk(clk), .arst_n(arst_n), .d_i(rst_pin_n_i), .q_o(rst_sync_n));

  runctl_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_halt_sync (
    .clk(clk), .arst_n(arst_n), .d_i(halt_pin_i), .q_o(halt_pin_s));

  runctl_rst_qual #(.RST_CYCLES(RST_CYCLES)) u_qual (
    .clk(clk), .arst_n(arst_n), .cyc_en_i(cyc_en_i),
    .rst_sync_n_i(rst_sync_n), .rst_take_o(rst_take));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) por_q <= 1'b1;
    else         por_q <= 1'b0;
  end

  assign core_rst_o = por_q | rst_take;

  runctl_halt #(.PIN_HALT_EN(PIN_HALT_EN)) u_halt (
    .clk(clk), .arst_n(arst_n), .cyc_en_i(cyc_en_i), .halt_req_i(halt_req_i),
    .halt_pin_s_i(halt_pin_s), .rst_i(core_rst_o), .halted_o(halted_o));

  assign core_clk_en_o  = cyc_en_i & ~halted_o;
  assign sk_latch_set_o = core_rst_o;

  // R4: power-on reset lasts a single cycle after release
  a_r4_por_single: assert property (@(posedge clk) disable iff (!arst_n)
    1'b1 |=> !por_q);

  // R10: while in reset the core cannot be frozen
  a_r10_reset_no_halt: assert property (@(posedge clk) disable iff (!arst_n)
    core_rst_o |=> !halted_o);
endmodule

// File: tb/tb_core_run_ctrl.sv
module tb_core_run_ctrl;
  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic cyc_en = 1'b0;
  logic rst_pin_n = 1'b1;
  logic halt_req = 1'b0;
  logic halt_pin = 1'b0;
  logic core_rst, core_clk_en, sk_set, halted;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  core_run_ctrl dut (
    .clk(clk), .arst_n(arst_n), .cyc_en_i(cyc_en), .rst_pin_n_i(rst_pin_n),
    .halt_req_i(halt_req), .halt_pin_i(halt_pin), .core_rst_o(core_rst),
    .core_clk_en_o(core_clk_en), .sk_latch_set_o(sk_set), .halted_o(halted));

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // instruction-cycle tick: one clock in four
  int div = 0;
  always @(negedge clk) begin
    #1;
    div = (div + 1) % 4;
    cyc_en = (div == 0);
  end

  // behavioural reference model
  int m_cnt;
  bit m_por, m_halted, m_hprev, rs, hs, rstc;
  bit rq[$];
  bit hq[$];
  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_cnt = 0; m_por = 1; m_halted = 0; m_hprev = 0;
      rq = '{1'b1, 1'b1};
      hq = '{1'b0, 1'b0};
    end else begin
      rs = rq[0];
      hs = hq[0];
      rstc = m_por || (m_cnt == 3);
      if (rstc) m_halted = 0;
      else if (!m_halted) m_halted = (halt_req && cyc_en) || hs;
      else if (m_hprev && !hs) m_halted = 0;
      if (rs) m_cnt = 0;
      else if (cyc_en && m_cnt < 3) m_cnt = m_cnt + 1;
      m_hprev = hs;
      m_por = 0;
      void'(rq.pop_front()); rq.push_back(rst_pin_n);
      void'(hq.pop_front()); hq.push_back(halt_pin);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (arst_n && !done) begin
      check("R1 core_rst", core_rst, m_por || (m_cnt == 3));
      check("R3 sk_latch_set", sk_set, m_por || (m_cnt == 3));
      check("R5 halted", halted, m_halted);
      check("R6 core_clk_en", core_clk_en, cyc_en && !m_halted);
    end
  end

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  bit seen;
  initial begin
    // R4 power-on state
    repeat (3) @(negedge clk);
    check("R4 rst during arst", core_rst, 1'b1);
    check("R4 halted during arst", halted, 1'b0);
    check("R3 sk during arst", sk_set, 1'b1);
    #2 arst_n = 1'b1;
    wait_clks(3);
    @(negedge clk);
    check("R4 rst released", core_rst, 1'b0);

    // R2 short low pulse ignored
    #2 rst_pin_n = 1'b0;
    wait_clks(6);
    rst_pin_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (core_rst) seen = 1;
    end
    check("R2 short pulse", seen, 1'b0);

    // R1 qualified reset
    #2 rst_pin_n = 1'b0;
    wait_clks(30);
    @(negedge clk);
    check("R1 long low accepted", core_rst, 1'b1);
    check("R3 sk set in reset", sk_set, 1'b1);
    #2 rst_pin_n = 1'b1;
    wait_clks(5);
    @(negedge clk);
    check("R1 released", core_rst, 1'b0);

    // R5/R6 halt by instruction
    #2 halt_req = 1'b1;
    wait_clks(8);
    halt_req = 1'b0;
    @(negedge clk);
    check("R5 instr halt", halted, 1'b1);
    seen = 0;
    #2 halt_req = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (core_clk_en) seen = 1;
    end
    #2 halt_req = 1'b0;
    check("R6 frozen clock", seen, 1'b0);
    wait_clks(10);
    @(negedge clk);
    check("R8 low pin no resume", halted, 1'b1);

    // R8 resume by pin edge
    #2 halt_pin = 1'b1;
    wait_clks(6);
    @(negedge clk);
    check("R7 still halted pin high", halted, 1'b1);
    #2 halt_pin = 1'b0;
    wait_clks(5);
    @(negedge clk);
    check("R8 resumed", halted, 1'b0);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (core_clk_en) seen = 1;
    end
    check("R8 clock back", seen, 1'b1);

    // R7 halt by pin
    #2 halt_pin = 1'b1;
    wait_clks(5);
    @(negedge clk);
    check("R7 pin halt", halted, 1'b1);
    #2 halt_pin = 1'b0;
    wait_clks(5);
    @(negedge clk);
    check("R8 pin resume", halted, 1'b0);

    // R9 reset while halted
    #2 halt_req = 1'b1;
    wait_clks(8);
    halt_req = 1'b0;
    @(negedge clk);
    check("R9 halted before reset", halted, 1'b1);
    #2 rst_pin_n = 1'b0;
    wait_clks(30);
    @(negedge clk);
    check("R9 reset exits halt", halted, 1'b0);
    check("R9 reset asserted", core_rst, 1'b1);

    // R10 halt sources ignored in reset, resume edge during reset
    #2 halt_pin = 1'b1; halt_req = 1'b1;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (halted) seen = 1;
    end
    #2 halt_pin = 1'b0; halt_req = 1'b0;
    check("R10 no halt in reset", seen, 1'b0);
    wait_clks(5);
    @(negedge clk);
    check("R10 reset kept over resume", core_rst, 1'b1);
    #2 rst_pin_n = 1'b1;
    wait_clks(6);
    @(negedge clk);
    check("R10 reset released", core_rst, 1'b0);
    check("R10 running", halted, 1'b0);

    wait_clks(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule